// File: doc/BRIEF.md
# Rule-Programmable Cellular Automaton Pattern Source

This block is a one-dimensional row of single-bit storage cells that produces a fresh parallel test pattern on each enabled clock. Every cell computes its next value from three bits: its own current value, the value of the cell below it (left, lower index) and the value of the cell above it (right, higher index). The function each cell applies is fixed at build time by an 8-bit rule number. That number is read as a three-input truth table, so every cell can run a different rule (a hybrid row) or all cells can share one rule (a uniform row).

A build parameter chooses how the two end cells see their missing neighbours. In the null mode the absent neighbours read as constant zero. In the ring mode the row wraps, so the lowest and highest cells are each other's neighbours. A load strobe writes a parallel seed into the row. A synchronous reset writes a nonzero default seed. The current cell contents are presented directly as the output pattern.

Top module: `ca_pattern_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the cells take the value of the `SEED` parameter (nonzero by default, 1). This happens regardless of `load` and `enable`.
- R2: With `rst` low and `load` high at a rising edge, the cells copy `seed`. This takes priority over `enable`.
- R3: With `rst`, `load` and `enable` all low at a rising edge, `pattern` keeps its value.
- R4: With only `enable` high, cell i takes bit k of its rule number. Here k = 4·right + 2·self + left, where left is cell i-1 and right is cell i+1.
- R5: In a uniform row of rule 90, each cell becomes left XOR right.
- R6: The default rule set alternates rule 90 (even cells, starting with cell 0) and rule 150 (odd cells, left XOR self XOR right).
- R7: In null mode, the left neighbour of cell 0 and the right neighbour of cell CELLS-1 read as 0.
- R8: In ring mode, cell CELLS-1 is the left neighbour of cell 0, and cell 0 is the right neighbour of cell CELLS-1.
- R9: A cell on rule 102 becomes self XOR left.
- R10: If every rule maps neighbourhood 0 to 0, an all-zero row that is stepped stays all-zero.
- R11: `pattern` is driven directly from the cell registers, so it changes only at a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; loads `SEED` |
| load | input | 1 | Parallel seed strobe |
| enable | input | 1 | Advance the row one step |
| seed | input | CELLS | Seed written on `load` |
| pattern | output | CELLS | Current cell contents |

## Verification
The bench builds three instances side by side. The first is an 8-cell null-boundary row with the default alternating 90/150 rules, which covers the hybrid row and both null ends. The second is a 5-cell ring whose cells mix rules 102, 150, 90 and 30; it makes the wrap-around neighbours and an asymmetric rule observable at both ends. The third is a 6-cell uniform rule-90 null row, which separates the uniform case from the hybrid one. Zero-row stepping, hold, load priority and seeds lodged at either end of each row are all compared against a behavioural model on every clock.

// File: rtl/ca_pkg.sv
package ca_pkg;

  typedef enum logic {
    BND_NULL = 1'b0,
    BND_RING = 1'b1
  } boundary_e;

  localparam int MAX_CELLS = 256;

  // Alternating 90 (even cells) / 150 (odd cells) rule table, cell 0 in the low byte.
  function automatic logic [8*MAX_CELLS-1:0] alt_rules();
    logic [8*MAX_CELLS-1:0] r;
    r = '0;
    for (int i = 0; i < MAX_CELLS; i++) begin
      r[8*i +: 8] = (i % 2 == 1) ? 8'd150 : 8'd90;
    end
    return r;
  endfunction

  // Truth-table lookup: neighbourhood index {right, self, left}.
  function automatic logic rule_eval(input logic [7:0] rule, input logic right,
                                     input logic self_v, input logic left);
    return rule[{right, self_v, left}];
  endfunction

  // True when every rule in the table sends neighbourhood 0 to 0.
  function automatic logic zero_keeping(input logic [8*MAX_CELLS-1:0] tab, input int n);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (tab[8*i]) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/ca_edge_wiring.sv
module ca_edge_wiring #(
  parameter int                CELLS    = 8,
  parameter ca_pkg::boundary_e BOUNDARY = ca_pkg::BND_NULL
) (
  input  logic [CELLS-1:0] state,
  output logic [CELLS-1:0] left_nb,
  output logic [CELLS-1:0] right_nb
);

  localparam int TOP = CELLS - 1;

  logic left_end;
  logic right_end;

  generate
    if (BOUNDARY == ca_pkg::BND_RING) begin : g_ring
      assign left_end  = state[TOP];   // R8
      assign right_end = state[0];
    end else begin : g_null
      assign left_end  = 1'b0;         // R7
      assign right_end = 1'b0;
    end
  endgenerate

  generate
    if (CELLS == 1) begin : g_single
      assign left_nb  = left_end;
      assign right_nb = right_end;
    end else begin : g_multi
      assign left_nb  = {state[TOP-1:0], left_end};
      assign right_nb = {right_end, state[TOP:1]};
    end
  endgenerate

endmodule

// File: rtl/ca_cell.sv
module ca_cell #(
  parameter logic [7:0] RULE      = 8'd90,
  parameter logic       RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic enable,
  input  logic seed_bit,
  input  logic left,
  input  logic right,
  output logic q
);

  logic nxt;

  always_comb begin
    nxt = ca_pkg::rule_eval(RULE, right, q, left);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RESET_VAL;
    end else if (load) begin
      q <= seed_bit;
    end else if (enable) begin
      q <= nxt;
    end
  end

endmodule

// File: rtl/ca_pattern_gen.sv
module ca_pattern_gen #(
  parameter int                   CELLS    = 8,
  parameter ca_pkg::boundary_e    BOUNDARY = ca_pkg::BND_NULL,
  parameter logic [8*CELLS-1:0]   RULES    = (8*CELLS)'(ca_pkg::alt_rules()),
  parameter logic [CELLS-1:0]     SEED     = CELLS'(1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             enable,
  input  logic [CELLS-1:0] seed,
  output logic [CELLS-1:0] pattern
);

  logic [CELLS-1:0] cells;
  logic [CELLS-1:0] left_nb;
  logic [CELLS-1:0] right_nb;

  ca_edge_wiring #(
    .CELLS    (CELLS),
    .BOUNDARY (BOUNDARY)
  ) u_edges (
    .state    (cells),
    .left_nb  (left_nb),
    .right_nb (right_nb)
  );

  generate
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
      ca_cell #(
        .RULE      (RULES[8*i +: 8]),
        .RESET_VAL (SEED[i])
      ) u_cell (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .enable   (enable),
        .seed_bit (seed[i]),
        .left     (left_nb[i]),
        .right    (right_nb[i]),
        .q        (cells[i])
      );
    end
  endgenerate

  assign pattern = cells;

endmodule

// File: rtl/ca_pattern_gen_chk.sv
module ca_pattern_gen_chk #(
  parameter int                 CELLS = 8,
  parameter logic [8*CELLS-1:0] RULES = '0,
  parameter logic [CELLS-1:0]   SEED  = '0
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic             enable,
  input logic [CELLS-1:0] seed,
  input logic [CELLS-1:0] pattern
);

  localparam logic KEEPS_ZERO =
    ca_pkg::zero_keeping(ca_pkg::MAX_CELLS*8'(RULES), CELLS);

  assert_reset_seed_R1: assert property (@(posedge clk)
    rst |=> pattern == SEED);

  assert_load_copies_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> pattern == $past(seed));

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && !enable) |=> $stable(pattern));

  assert_known_R11: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(pattern));

  generate
    if (KEEPS_ZERO) begin : g_zero
      assert_zero_stays_R10: assert property (@(posedge clk) disable iff (rst)
        (enable && !load && pattern == '0) |=> pattern == '0);
    end
  endgenerate

endmodule

bind ca_pattern_gen ca_pattern_gen_chk #(
  .CELLS (CELLS),
  .RULES (RULES),
  .SEED  (SEED)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .load    (load),
  .enable  (enable),
  .seed    (seed),
  .pattern (pattern)
);

// File: tb/ca_pattern_gen_test.sv
module ca_pattern_gen_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, load = 1'b0, enable = 1'b0;
  logic [7:0] sa = '0;
  logic [4:0] sb = '0;
  logic [5:0] sc = '0;
  logic [7:0] pa;
  logic [4:0] pb;
  logic [5:0] pc;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  int rl[3][16];
  int ma, mb, mc;

  // A: 8 cells, null, default rules, SEED 1
  ca_pattern_gen uut (.clk(clk), .rst(rst), .load(load), .enable(enable), .seed(sa), .pattern(pa));

  // B: 5-cell ring, cell0..4 = 102,150,90,102,30
  ca_pattern_gen #(.CELLS(5), .BOUNDARY(ca_pkg::BND_RING),
    .RULES({8'd30, 8'd102, 8'd90, 8'd150, 8'd102}), .SEED(5'b00100))
    uut_ring (.clk(clk), .rst(rst), .load(load), .enable(enable), .seed(sb), .pattern(pb));

  // C: 6-cell null uniform rule 90
  ca_pattern_gen #(.CELLS(6), .RULES({6{8'd90}}), .SEED(6'h21))
    uut_uni (.clk(clk), .rst(rst), .load(load), .enable(enable), .seed(sc), .pattern(pc));

  function automatic int nxt(int st, int n, bit ring, int w);
    int res = 0;
    for (int i = 0; i < n; i++) begin
      int l, s, r, k;
      s = (st >> i) & 1;
      if (i == 0) l = ring ? ((st >> (n-1)) & 1) : 0; else l = (st >> (i-1)) & 1;
      if (i == n-1) r = ring ? (st & 1) : 0; else r = (st >> (i+1)) & 1;
      k = 4*r + 2*s + l;
      res |= ((rl[w][i] >> k) & 1) << i;
    end
    return res;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit rs, bit ld, bit en, string ta, string tb, string tc);
    int ea, eb, ec;
    rst = rs; load = ld; enable = en;
    ea = rs ? 1     : ld ? int'(sa) : en ? nxt(ma, 8, 0, 0) : ma;
    eb = rs ? 4     : ld ? int'(sb) : en ? nxt(mb, 5, 1, 1) : mb;
    ec = rs ? 'h21  : ld ? int'(sc) : en ? nxt(mc, 6, 0, 2) : mc;
    @(posedge clk); #1;
    check(ta, int'(pa), ea); check(tb, int'(pb), eb); check(tc, int'(pc), ec);
    ma = ea; mb = eb; mc = ec;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      rl[0][i] = (i % 2) ? 150 : 90;
      rl[2][i] = 90;
      rl[1][i] = 0;
    end
    rl[1][0] = 102; rl[1][1] = 150; rl[1][2] = 90; rl[1][3] = 102; rl[1][4] = 30;
    ma = 0; mb = 0; mc = 0;

    // R1 reset seeds, even with load/enable asserted
    step(1, 0, 0, "R1", "R1", "R1");
    sa = 8'hFF; sb = 5'h1F; sc = 6'h3F;
    step(1, 1, 1, "R1", "R1", "R1");
    // R6 hybrid, R8 ring, R5 uniform 90
    for (int k = 0; k < 20; k++) step(0, 0, 1, "R6", "R8", "R5");
    // R3 hold
    for (int k = 0; k < 5; k++) step(0, 0, 0, "R3", "R3", "R3");
    // R2 load beats enable
    sa = 8'h5C; sb = 5'b10011; sc = 6'h12;
    step(0, 1, 1, "R2", "R2", "R2");
    for (int k = 0; k < 30; k++) step(0, 0, 1, "R4", "R9", "R4");
    // R10 zero row
    sa = 0; sb = 0; sc = 0;
    step(0, 1, 0, "R2", "R2", "R2");
    for (int k = 0; k < 6; k++) step(0, 0, 1, "R10", "R10", "R10");
    // R7 / R8 end cells: seed at top cell
    sa = 8'h80; sb = 5'h10; sc = 6'h20;
    step(0, 1, 0, "R2", "R2", "R2");
    for (int k = 0; k < 12; k++) step(0, 0, 1, "R7", "R8", "R7");
    // seed at bottom cell
    sa = 8'h01; sb = 5'h01; sc = 6'h01;
    step(0, 1, 0, "R2", "R2", "R2");
    for (int k = 0; k < 12; k++) step(0, 0, 1, "R7", "R9", "R7");
    // R11 output steady between edges
    begin
      logic [7:0] snap;
      snap = pa;
      #3;
      check("R11", int'(pa), int'(snap));
    end
    // interleaved enable
    for (int k = 0; k < 10; k++) step(0, 0, k[0], "R3", "R4", "R3");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule